// File: doc/BRIEF.md
# Dual-Direction UART Byte Queue with Fill-Level Interrupts

This block buffers traffic between a UART's serial engine and a register bus. It holds a transmit queue of bytes and a receive queue of 12-bit entries. Each receive entry is one received byte together with four error flags. On the bus side a single data port is used for both directions: a write pushes a byte for transmission and a read pops the oldest receive entry. On the line side the serializer pops transmit bytes and the deserializer pushes received bytes and their error flags, each with a one-cycle strobe.

A configuration interface sets the queue-enable bit and the interrupt trigger level for each direction. Either part can be written on its own. While the enable bit is clear, each queue acts as a single-entry holding register. When the bit is set, each queue holds `DEPTH` entries. Any change of the enable bit empties both queues. If a byte arrives while the receive side is full, the byte is dropped and a sticky overrun flag is set. The flag stays set until the clear strobe is pulsed.

Each direction raises an interrupt based on how full its queue is. The receive interrupt asserts when the fill count reaches the chosen fraction of depth. The transmit interrupt asserts when the fill count has drained down to the chosen fraction.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset the queues are in single-entry mode, both are empty, not full and free of overrun, and both trigger levels are the one-half code (2). With the queues enabled and no level ever written, the receive interrupt is low at 7 entries and high at 8.
- R2: In single-entry mode each queue is full after one accepted entry. Any further push is discarded and the held entry stays unchanged.
- R3: In enabled mode each queue is first-in first-out with DEPTH (16) entries and is full at DEPTH. A push while full is discarded. A pop while empty has no effect. Whether a push is accepted depends on the state before any pop in the same cycle, so a push and a pop together on a full queue leave it at DEPTH-1.
- R4: A receive entry reads as error flags in bits 11:8 and data in bits 7:0. `bus_rdata` always shows the oldest entry. When the receive queue is empty it shows 0, and a read changes nothing.
- R5: A receive push while `rx_full` is high sets `rx_overrun` on the next cycle. The flag stays set until `ovr_clr` is pulsed. If set and clear happen in the same cycle, set wins.
- R6: The level codes 0, 1, 2, 3 and 4 select thresholds of DEPTH/8, DEPTH/4, DEPTH/2, 3·DEPTH/4 and 7·DEPTH/8 (2, 4, 8, 12 and 14 at depth 16). Codes 5, 6 and 7 act as code 2.
- R7: In enabled mode, `rx_irq` is high exactly when the receive fill count is at or above the receive threshold.
- R8: In enabled mode, `tx_irq` is high exactly when the transmit fill count is at or below the transmit threshold.
- R9: In single-entry mode, `rx_irq` equals not `rx_empty` and `tx_irq` equals `tx_empty`.
- R10: A configuration write that changes the enable bit empties both queues, and this takes priority over any push in the same cycle. A write that leaves the bit unchanged, or a write of the levels alone, keeps the queue contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_wr | input | 1 | Strobe that writes the enable bit |
| cfg_en | input | 1 | New enable bit value |
| cfg_lvl_wr | input | 1 | Strobe that writes both level codes |
| cfg_tx_lvl | input | 3 | Transmit level code |
| cfg_rx_lvl | input | 3 | Receive level code |
| bus_wr | input | 1 | Bus write to the data port (transmit push) |
| bus_wdata | input | 8 | Byte to transmit |
| bus_rd | input | 1 | Bus read of the data port (receive pop) |
| bus_rdata | output | 12 | Oldest receive entry {err, data}, or 0 when empty |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 4 | Error flags for the received byte |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_irq | output | 1 | Receive level interrupt |

## Verification
The hardest situations to reach are the exact crossing of each threshold for all eight level codes, and a full receive queue that meets a late byte while the overrun clear is pulsed in the same cycle. The stimulus covers the first by sweeping every level code: it fills each queue one entry at a time from empty to full and drains it again, and compares the interrupts with thresholds the bench computes at every fill count. For the overrun case, the stimulus fills the single-entry holding register, which takes one push, and then pulses the receive push and the clear together. Mode changes are made while both queues hold data, including in the same cycle as a push, to show that the flush takes priority.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 4;
    localparam int LVL_W  = 3;
    localparam int RX_W   = DATA_W + ERR_W;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_EIGHTH   = 3'd0;
    localparam lvl_t LVL_QUARTER  = 3'd1;
    localparam lvl_t LVL_HALF     = 3'd2;
    localparam lvl_t LVL_3QUARTER = 3'd3;
    localparam lvl_t LVL_7EIGHTH  = 3'd4;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic en;
        lvl_t tx_lvl;
        lvl_t rx_lvl;
        logic ovr;
    } ctl_t;

endpackage

// File: rtl/uart_fifo_queue.sv
module uart_fifo_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          deep,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t            s_d, s_q;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    // capacity selects holding-register or full-depth behaviour
    assign cap     = deep ? CW'(DEPTH) : CW'(1);
    assign full    = (s_q.cnt >= cap);
    assign empty   = (s_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = wdata;
                s_d.wp          = s_q.wp + AW'(1);
            end
            if (do_pop) begin
                s_d.rp = s_q.rp + AW'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + CW'(1);
                2'b01:   s_d.cnt = s_q.cnt - CW'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;

endmodule

// File: rtl/uart_fifo_lvl.sv
module uart_fifo_lvl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  lvl_t          code,
    output logic [CW-1:0] thr
);

    localparam logic [CW-1:0] T_EIGHTH   = CW'(DEPTH / 8);
    localparam logic [CW-1:0] T_QUARTER  = CW'(DEPTH / 4);
    localparam logic [CW-1:0] T_HALF     = CW'(DEPTH / 2);
    localparam logic [CW-1:0] T_3QUARTER = CW'((DEPTH * 3) / 4);
    localparam logic [CW-1:0] T_7EIGHTH  = CW'((DEPTH * 7) / 8);

    always_comb begin
        unique case (code)
            LVL_EIGHTH:   thr = T_EIGHTH;
            LVL_QUARTER:  thr = T_QUARTER;
            LVL_HALF:     thr = T_HALF;
            LVL_3QUARTER: thr = T_3QUARTER;
            LVL_7EIGHTH:  thr = T_7EIGHTH;
            default:      thr = T_HALF;   // reserved codes
        endcase
    end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en_wr,
    input  logic              cfg_en,
    input  logic              cfg_lvl_wr,
    input  logic [LVL_W-1:0]  cfg_tx_lvl,
    input  logic [LVL_W-1:0]  cfg_rx_lvl,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [RX_W-1:0]   bus_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              ovr_clr,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              tx_irq,
    output logic              rx_irq
);

    localparam int CW = $clog2(DEPTH + 1);

    ctl_t            st_d, st_q;
    logic            flush;
    logic            rx_lost;
    logic            fifo_on;
    logic [CW-1:0]   tx_cnt, rx_cnt, tx_thr, rx_thr;
    logic [RX_W-1:0] rx_head;
    rx_entry_t       rx_in;

    assign flush   = cfg_en_wr && (cfg_en != st_q.en);
    assign rx_lost = rx_push && rx_full;
    assign fifo_on = st_q.en;

    always_comb begin
        st_d = st_q;
        if (cfg_en_wr) st_d.en = cfg_en;
        if (cfg_lvl_wr) begin
            st_d.tx_lvl = cfg_tx_lvl;
            st_d.rx_lvl = cfg_rx_lvl;
        end
        if (ovr_clr) st_d.ovr = 1'b0;
        if (rx_lost) st_d.ovr = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, tx_lvl: LVL_HALF, rx_lvl: LVL_HALF, ovr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    uart_fifo_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .deep  (st_q.en),
        .push  (bus_wr),
        .pop   (tx_pop),
        .wdata (bus_wdata),
        .head  (tx_data),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    assign rx_in = '{err: rx_err, data: rx_data};

    uart_fifo_queue #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .deep  (st_q.en),
        .push  (rx_push),
        .pop   (bus_rd),
        .wdata (rx_in),
        .head  (rx_head),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    uart_fifo_lvl #(.DEPTH(DEPTH)) u_txlvl (.code(st_q.tx_lvl), .thr(tx_thr));
    uart_fifo_lvl #(.DEPTH(DEPTH)) u_rxlvl (.code(st_q.rx_lvl), .thr(rx_thr));

    assign bus_rdata  = rx_empty ? '0 : rx_head;
    assign rx_overrun = st_q.ovr;
    assign rx_irq     = st_q.en ? (rx_cnt >= rx_thr) : !rx_empty;
    assign tx_irq     = st_q.en ? (tx_cnt <= tx_thr) : tx_empty;

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
    parameter int RW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_on,
    input logic          cfg_en_wr,
    input logic          cfg_en,
    input logic          bus_rd,
    input logic          rx_push,
    input logic          ovr_clr,
    input logic [RW-1:0] bus_rdata,
    input logic          tx_empty,
    input logic          tx_full,
    input logic          rx_empty,
    input logic          rx_full,
    input logic          rx_overrun,
    input logic          tx_irq,
    input logic          rx_irq
);

    p_tx_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_empty && tx_full));

    p_rx_hold_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !bus_rd && !cfg_en_wr |=> rx_full);

    p_one_deep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on && !rx_empty |-> rx_full);

    p_rdata_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> bus_rdata == '0);

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full |=> rx_overrun);

    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun && !ovr_clr |=> rx_overrun);

    p_rx_irq_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && rx_full |-> rx_irq);

    p_tx_irq_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && tx_empty |-> tx_irq);

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (rx_irq == rx_full) && (tx_irq == !tx_full));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_wr && (cfg_en != fifo_on) |=> tx_empty && rx_empty);

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.RW(uart_fifo_pkg::RX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_on    (fifo_on),
    .cfg_en_wr  (cfg_en_wr),
    .cfg_en     (cfg_en),
    .bus_rd     (bus_rd),
    .rx_push    (rx_push),
    .ovr_clr    (ovr_clr),
    .bus_rdata  (bus_rdata),
    .tx_empty   (tx_empty),
    .tx_full    (tx_full),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq)
);

// File: tb/tb_uart_fifo_pair.sv
module tb_uart_fifo_pair;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en_wr, cfg_en, cfg_lvl_wr;
    logic [2:0]  cfg_tx_lvl, cfg_rx_lvl;
    logic        bus_wr, bus_rd, tx_pop, rx_push, ovr_clr;
    logic [7:0]  bus_wdata, rx_data, tx_data;
    logic [3:0]  rx_err;
    logic [11:0] bus_rdata;
    logic        tx_empty, tx_full, rx_empty, rx_full, rx_overrun, tx_irq, rx_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_pair #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_en_wr(cfg_en_wr), .cfg_en(cfg_en), .cfg_lvl_wr(cfg_lvl_wr),
        .cfg_tx_lvl(cfg_tx_lvl), .cfg_rx_lvl(cfg_rx_lvl),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data),
        .rx_push(rx_push), .rx_data(rx_data), .rx_err(rx_err), .ovr_clr(ovr_clr),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_thr(input int code);
        case (code)
            0: return DEPTH / 8;
            1: return DEPTH / 4;
            3: return DEPTH * 3 / 4;
            4: return DEPTH * 7 / 8;
            default: return DEPTH / 2;
        endcase
    endfunction

    function automatic int ent(input int k);
        return ((k & 15) << 8) | ((k * 37 + 5) & 255);
    endfunction

    // inputs change 1 time unit after a rising edge; outputs are read there too
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_rx(input int k);
        rx_push = 1'b1; rx_data = 8'((k * 37 + 5) & 255); rx_err = 4'(k & 15);
        step();
        rx_push = 1'b0;
    endtask

    task automatic wr_tx(input int v);
        bus_wr = 1'b1; bus_wdata = 8'(v);
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_rx();
        bus_rd = 1'b1; step(); bus_rd = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1; step(); tx_pop = 1'b0;
    endtask

    task automatic set_en(input bit b);
        cfg_en_wr = 1'b1; cfg_en = b; step(); cfg_en_wr = 1'b0;
    endtask

    task automatic set_lvl(input int t, input int r);
        cfg_lvl_wr = 1'b1; cfg_tx_lvl = 3'(t); cfg_rx_lvl = 3'(r);
        step(); cfg_lvl_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_en_wr = 0; cfg_en = 0; cfg_lvl_wr = 0; cfg_tx_lvl = 0; cfg_rx_lvl = 0;
        bus_wr = 0; bus_wdata = 0; bus_rd = 0; tx_pop = 0;
        rx_push = 0; rx_data = 0; rx_err = 0; ovr_clr = 0;
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state, R9 single-entry interrupts
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 rx_empty", int'(rx_empty), 1);
        chk("R1 tx_full", int'(tx_full), 0);
        chk("R1 rx_full", int'(rx_full), 0);
        chk("R1 overrun", int'(rx_overrun), 0);
        chk("R9 tx_irq reset", int'(tx_irq), 1);
        chk("R9 rx_irq reset", int'(rx_irq), 0);
        chk("R4 rdata empty", int'(bus_rdata), 0);

        // single-entry receive
        push_rx(1);
        chk("R2 rx_full one", int'(rx_full), 1);
        chk("R9 rx_irq one", int'(rx_irq), 1);
        chk("R4 rdata layout", int'(bus_rdata), ent(1));
        push_rx(2);
        chk("R5 overrun set", int'(rx_overrun), 1);
        chk("R2 held kept", int'(bus_rdata), ent(1));
        rd_rx();
        chk("R2 rx_empty", int'(rx_empty), 1);
        chk("R4 rdata zero", int'(bus_rdata), 0);
        chk("R5 sticky", int'(rx_overrun), 1);
        rd_rx();
        chk("R4 read empty", int'(rx_empty), 1);
        ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
        chk("R5 cleared", int'(rx_overrun), 0);
        push_rx(3);
        ovr_clr = 1'b1; push_rx(4); ovr_clr = 1'b0;
        chk("R5 set wins", int'(rx_overrun), 1);
        chk("R2 held kept 2", int'(bus_rdata), ent(3));
        rd_rx();
        ovr_clr = 1'b1; step(); ovr_clr = 1'b0;

        // single-entry transmit
        wr_tx(8'h5C);
        chk("R2 tx_full one", int'(tx_full), 1);
        chk("R9 tx_irq held", int'(tx_irq), 0);
        wr_tx(8'h77);
        chk("R2 tx held kept", int'(tx_data), 8'h5C);
        pop_tx();
        chk("R9 tx_irq empty", int'(tx_irq), 1);
        pop_tx();
        chk("R3 pop empty", int'(tx_empty), 1);

        // enable, default half level
        set_en(1'b1);
        for (int k = 1; k <= DEPTH; k++) begin
            push_rx(k);
            chk("R1 default level", int'(rx_irq), int'(k >= DEPTH / 2));
            chk("R3 rx_full deep", int'(rx_full), int'(k == DEPTH));
        end
        push_rx(99);
        chk("R5 overrun deep", int'(rx_overrun), 1);
        for (int k = 1; k <= DEPTH; k++) begin
            chk("R3 R4 order", int'(bus_rdata), ent(k));
            rd_rx();
        end
        chk("R3 drained", int'(rx_empty), 1);
        ovr_clr = 1'b1; step(); ovr_clr = 1'b0;

        // R6 R7 R8 sweep of all level codes
        for (int c = 0; c < 8; c++) begin
            int thr;
            thr = exp_thr(c);
            set_lvl(c, c);
            for (int k = 1; k <= DEPTH; k++) begin
                push_rx(k + c);
                chk("R6 R7 rx_irq fill", int'(rx_irq), int'(k >= thr));
            end
            for (int k = 1; k <= DEPTH; k++) begin
                chk("R3 rx order", int'(bus_rdata), ent(k + c));
                rd_rx();
                chk("R6 R7 rx_irq drain", int'(rx_irq), int'((DEPTH - k) >= thr));
            end
            chk("R8 tx_irq empty", int'(tx_irq), 1);
            for (int k = 1; k <= DEPTH; k++) begin
                wr_tx((k * 3 + c) & 255);
                chk("R6 R8 tx_irq fill", int'(tx_irq), int'(k <= thr));
                chk("R3 tx_full", int'(tx_full), int'(k == DEPTH));
            end
            for (int k = 1; k <= DEPTH; k++) begin
                chk("R3 tx order", int'(tx_data), (k * 3 + c) & 255);
                pop_tx();
            end
        end

        // R3 push and pop together on a full queue
        set_lvl(2, 2);
        for (int k = 1; k <= DEPTH; k++) wr_tx(k);
        bus_wr = 1'b1; bus_wdata = 8'hEE; tx_pop = 1'b1;
        step();
        bus_wr = 1'b0; tx_pop = 1'b0;
        chk("R3 push+pop full", int'(tx_full), 0);
        chk("R3 head after", int'(tx_data), 2);

        // R10 configuration writes that keep contents
        push_rx(40); push_rx(41); push_rx(42);
        set_lvl(0, 0);
        chk("R10 lvl keeps", int'(bus_rdata), ent(40));
        set_en(1'b1);
        chk("R10 same en keeps", int'(rx_empty), 0);
        chk("R10 same en head", int'(bus_rdata), ent(40));

        // R10 toggle flushes both
        set_en(1'b0);
        chk("R10 flush rx", int'(rx_empty), 1);
        chk("R10 flush tx", int'(tx_empty), 1);
        push_rx(50);
        chk("R2 after disable", int'(rx_full), 1);

        // flush beats a push in the same cycle
        rx_push = 1'b0;
        cfg_en_wr = 1'b1; cfg_en = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h33;
        step();
        cfg_en_wr = 1'b0; bus_wr = 1'b0;
        chk("R10 flush over push tx", int'(tx_empty), 1);
        chk("R10 flush rx2", int'(rx_empty), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule